// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Edge Interrupts

This block controls several banks of 32 general-purpose pins through one 32-bit register port. Software picks each pin's direction and polarity, reads pin levels, and drives outputs through a set register and a clear register. Because of these two registers, software never has to read, modify and write back the output state. Inputs pass through a two-flop synchronizer. After polarity inversion they feed a per-pin edge detector with separate enables for rising and falling transitions.

A detected edge sets a pending bit in the bank's status register and records the edge's direction in an edge-kind register. Software clears both registers by writing ones. A single interrupt line is high while any pending bit in any bank is set. Registers are grouped by function. Inside each group, bank `b` sits at `group_base + 4*b`.

Top module: `gpio_banks_top`

## Requirements
- R1: After reset, every register reads zero, `pad_oe` and `pad_out` are all zero, and `irq` is low.
- R2: The byte address decodes as `addr[7:4]` = group and `addr[3:2]` = bank, and `addr[1:0]` is ignored. The groups are: 0x0 direction, 0x1 polarity, 0x2 level (read only), 0x3 set (write only), 0x4 clear (write only), 0x5 rise enable, 0x6 fall enable, 0x9 pending, 0xA edge kind. The other groups and any bank index of `NUM_BANKS` or above read zero and ignore writes. The set and clear groups read zero, and writes to the level group are ignored.
- R3: A direction bit of 1 makes pin n of that bank an output, so `pad_oe` for that pin is 1. A direction bit of 0 makes the pin an input. Direction, polarity and both enable registers read back what was written.
- R4: Writing the set group raises the output latch of every output pin whose write bit is 1. Writing the clear group lowers it. Latch bits of input pins, and bits written as 0, are unchanged.
- R5: A polarity bit of 1 inverts the pin. `pad_out` equals the output latch XOR polarity, and an input's logical level is the synchronized pad XOR polarity.
- R6: Reading the level group returns, for each pin, the output latch if the pin is an output. For an input, it returns the logical level of the pad.
- R7: A logical 0-to-1 transition of a pin with its rise-enable bit set sets the pin's pending bit. A 1-to-0 transition with its fall-enable bit set does the same. With both enable bits at 0, the pin never sets a pending bit. A pad change is visible in the pending register three clocks after it is sampled.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. `irq` is high while any pending bit in any bank is 1.
- R9: When a pending event is latched, its edge-kind bit becomes 1 for a rising edge and 0 for a falling edge. Writing 1 to an edge-kind bit clears it.
- R10: If an edge event and a clear write of the same pending bit happen in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32*NUM_BANKS | Pad levels, bank b at bits [32b+31:32b] |
| pad_out | output | 32*NUM_BANKS | Driven pad values |
| pad_oe | output | 32*NUM_BANKS | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an edge event and a software clear of the same pending bit in the same cycle. The edge reaches the status logic only after the synchronizer and the previous-level register. To get there, the bench arms both enables, latches a rising event, then flips the pad. It counts two rising clock edges and places the clear write in the exact cycle in which the falling event is presented. The bench also sweeps every pin of every bank through all four enable combinations and every address slot of the decode space.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PIN_W  = 32;
    localparam int ADDR_W = 8;
    localparam int SLOT_W = 2;

    typedef enum logic [3:0] {
        GRP_DIR  = 4'h0,
        GRP_POL  = 4'h1,
        GRP_LVL  = 4'h2,
        GRP_SET  = 4'h3,
        GRP_CLR  = 4'h4,
        GRP_RISE = 4'h5,
        GRP_FALL = 4'h6,
        GRP_PEND = 4'h9,
        GRP_KIND = 4'hA
    } grp_e;

    typedef struct packed {
        logic dir;
        logic pol;
        logic set;
        logic clr;
        logic rise;
        logic fall;
        logic pend;
        logic kind;
    } wr_strb_t;

    typedef struct packed {
        logic [PIN_W-1:0] dir;
        logic [PIN_W-1:0] pol;
        logic [PIN_W-1:0] out;
        logic [PIN_W-1:0] ren;
        logic [PIN_W-1:0] fen;
        logic [PIN_W-1:0] pend;
        logic [PIN_W-1:0] kind;
        logic [PIN_W-1:0] lvl_prev;
    } bank_state_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_q, s1_d, s2_q, s2_d;

    always_comb begin
        s1_d = async_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    output logic                 hit_o,
    output logic [SLOT_W-1:0]    slot_o,
    output grp_e                 grp_o,
    output logic [NUM_BANKS-1:0] bank_sel_o,
    output wr_strb_t             strb_o
);
    logic       grp_ok;
    logic       slot_ok;
    logic [3:0] grp_raw;
    logic       unused_lo;

    assign unused_lo = ^addr[1:0];
    assign grp_raw   = addr[7:4];
    assign slot_o    = addr[3:2];
    assign slot_ok   = (32'(slot_o) < NUM_BANKS);

    always_comb begin
        grp_ok = 1'b1;
        grp_o  = GRP_DIR;
        case (grp_raw)
            4'h0: grp_o = GRP_DIR;
            4'h1: grp_o = GRP_POL;
            4'h2: grp_o = GRP_LVL;
            4'h3: grp_o = GRP_SET;
            4'h4: grp_o = GRP_CLR;
            4'h5: grp_o = GRP_RISE;
            4'h6: grp_o = GRP_FALL;
            4'h9: grp_o = GRP_PEND;
            4'hA: grp_o = GRP_KIND;
            default: grp_ok = 1'b0;
        endcase
    end

    assign hit_o = grp_ok && slot_ok;

    always_comb begin
        strb_o = '0;
        if (wr && hit_o) begin
            strb_o.dir  = (grp_o == GRP_DIR);
            strb_o.pol  = (grp_o == GRP_POL);
            strb_o.set  = (grp_o == GRP_SET);
            strb_o.clr  = (grp_o == GRP_CLR);
            strb_o.rise = (grp_o == GRP_RISE);
            strb_o.fall = (grp_o == GRP_FALL);
            strb_o.pend = (grp_o == GRP_PEND);
            strb_o.kind = (grp_o == GRP_KIND);
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        assign bank_sel_o[b] = hit_o && (32'(slot_o) == b);
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  wr_strb_t         strb,
    input  logic [PIN_W-1:0] wdata,
    input  logic [PIN_W-1:0] pad_sync,
    output logic [PIN_W-1:0] dir_o,
    output logic [PIN_W-1:0] pol_o,
    output logic [PIN_W-1:0] ren_o,
    output logic [PIN_W-1:0] fen_o,
    output logic [PIN_W-1:0] pend_o,
    output logic [PIN_W-1:0] kind_o,
    output logic [PIN_W-1:0] lvl_o,
    output logic [PIN_W-1:0] pad_out_o,
    output logic [PIN_W-1:0] pad_oe_o
);
    bank_state_t st_q, st_d;
    logic [PIN_W-1:0] lvl, rise_evt, fall_evt, evt;
    logic [PIN_W-1:0] pend_clr, kind_clr, kind_keep;
    logic set_we, clr_we, dir_we, pend_we;

    assign set_we  = sel && strb.set;
    assign clr_we  = sel && strb.clr;
    assign dir_we  = sel && strb.dir;
    assign pend_we = sel && strb.pend;

    always_comb begin
        lvl      = pad_sync ^ st_q.pol;
        rise_evt = lvl & ~st_q.lvl_prev & st_q.ren;
        fall_evt = ~lvl & st_q.lvl_prev & st_q.fen;
        evt      = rise_evt | fall_evt;
        pend_clr = pend_we ? wdata : '0;
        kind_clr = (sel && strb.kind) ? wdata : '0;

        st_d          = st_q;
        st_d.lvl_prev = lvl;
        if (dir_we)             st_d.dir = wdata;
        if (sel && strb.pol)    st_d.pol = wdata;
        if (sel && strb.rise)   st_d.ren = wdata;
        if (sel && strb.fall)   st_d.fen = wdata;
        if (set_we)             st_d.out = st_q.out | (wdata & st_q.dir);
        if (clr_we)             st_d.out = st_q.out & ~(wdata & st_q.dir);
        st_d.pend = (st_q.pend & ~pend_clr) | evt;
        kind_keep = st_q.kind & ~kind_clr;
        st_d.kind = (kind_keep & ~evt) | rise_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_o     = st_q.dir;
    assign pol_o     = st_q.pol;
    assign ren_o     = st_q.ren;
    assign fen_o     = st_q.fen;
    assign pend_o    = st_q.pend;
    assign kind_o    = st_q.kind;
    assign lvl_o     = (st_q.dir & st_q.out) | (~st_q.dir & lvl);
    assign pad_out_o = st_q.out ^ st_q.pol;
    assign pad_oe_o  = st_q.dir;

    // R8 / R10: a pending bit leaves only through a write of 1
    assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.pend & $past(st_q.pend & ~pend_clr)) == $past(st_q.pend & ~pend_clr)));

    // R7: new pending bits appear only on pins with an enable set
    assert_pend_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (((st_q.pend & ~$past(st_q.pend)) & ~$past(st_q.ren | st_q.fen)) == '0));

    // R4: the output latch moves only on a set or clear write
    assert_out_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(st_q.out));

    // R3: direction changes only on a direction write
    assert_dir_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_we |=> $stable(st_q.dir));
endmodule

// File: rtl/gpio_banks_top.sv
module gpio_banks_top
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int PADS = NUM_BANKS * PIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PADS-1:0]   pad_in,
    output logic [PADS-1:0]   pad_out,
    output logic [PADS-1:0]   pad_oe,
    output logic              irq
);
    logic                 hit;
    logic [SLOT_W-1:0]    slot;
    grp_e                 grp;
    logic [NUM_BANKS-1:0] bank_sel;
    wr_strb_t             strb;
    logic [PADS-1:0]      pad_sync;

    logic [PIN_W-1:0] dir_v  [NUM_BANKS];
    logic [PIN_W-1:0] pol_v  [NUM_BANKS];
    logic [PIN_W-1:0] ren_v  [NUM_BANKS];
    logic [PIN_W-1:0] fen_v  [NUM_BANKS];
    logic [PIN_W-1:0] pend_v [NUM_BANKS];
    logic [PIN_W-1:0] kind_v [NUM_BANKS];
    logic [PIN_W-1:0] lvl_v  [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;

    gpio_addr_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr       (bus_addr),
        .wr         (bus_wr),
        .hit_o      (hit),
        .slot_o     (slot),
        .grp_o      (grp),
        .bank_sel_o (bank_sel),
        .strb_o     (strb)
    );

    gpio_sync #(.W(PADS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (pad_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (bank_sel[b]),
            .strb      (strb),
            .wdata     (bus_wdata),
            .pad_sync  (pad_sync[b*PIN_W +: PIN_W]),
            .dir_o     (dir_v[b]),
            .pol_o     (pol_v[b]),
            .ren_o     (ren_v[b]),
            .fen_o     (fen_v[b]),
            .pend_o    (pend_v[b]),
            .kind_o    (kind_v[b]),
            .lvl_o     (lvl_v[b]),
            .pad_out_o (pad_out[b*PIN_W +: PIN_W]),
            .pad_oe_o  (pad_oe[b*PIN_W +: PIN_W])
        );
        assign bank_irq[b] = |pend_v[b];
    end

    assign irq = |bank_irq;

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit && (32'(slot) == b)) begin
                case (grp)
                    GRP_DIR:  bus_rdata = dir_v[b];
                    GRP_POL:  bus_rdata = pol_v[b];
                    GRP_LVL:  bus_rdata = lvl_v[b];
                    GRP_RISE: bus_rdata = ren_v[b];
                    GRP_FALL: bus_rdata = fen_v[b];
                    GRP_PEND: bus_rdata = pend_v[b];
                    GRP_KIND: bus_rdata = kind_v[b];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    // R2: an address outside the map always reads zero
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_banks_top.sv
module sim_gpio_banks_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;
    localparam int PW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NB*PW-1:0] pad_in = '0;
    logic [NB*PW-1:0] pad_out, pad_oe;
    logic irq;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    logic [31:0] m_dir [NB], m_pol [NB], m_out [NB], m_ren [NB], m_fen [NB];
    logic [31:0] m_pend [NB], m_kind [NB];
    logic [31:0] rnd = 32'h1d2c3b4a;

    gpio_banks_top #(.NUM_BANKS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] nxt(logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    function automatic logic [7:0] ad(int g, int b);
        return 8'((g << 4) | (b << 2));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int g, int b, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ad(g, b); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int g, int b, output logic [31:0] d);
        @(negedge clk);
        bus_addr = ad(g, b);
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_lvl(int b);
        return (m_dir[b] & m_out[b]) | (~m_dir[b] & (pad_in[b*PW +: PW] ^ m_pol[b]));
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int b = 0; b < NB; b++) r |= |m_pend[b];
        return r;
    endfunction

    task automatic check_all(string req);
        logic [31:0] v;
        for (int b = 0; b < NB; b++) begin
            rd(0, b, v);  check(req, v, m_dir[b]);
            rd(1, b, v);  check(req, v, m_pol[b]);
            rd(2, b, v);  check(req, v, exp_lvl(b));
            rd(5, b, v);  check(req, v, m_ren[b]);
            rd(6, b, v);  check(req, v, m_fen[b]);
            rd(9, b, v);  check(req, v, m_pend[b]);
            rd(10, b, v); check(req, v, m_kind[b]);
            check(req, pad_out[b*PW +: PW], m_out[b] ^ m_pol[b]);
            check(req, pad_oe[b*PW +: PW], m_dir[b]);
        end
        check(req, 32'(irq), 32'(exp_irq()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int b = 0; b < NB; b++) begin
            m_dir[b] = 0; m_pol[b] = 0; m_out[b] = 0; m_ren[b] = 0;
            m_fen[b] = 0; m_pend[b] = 0; m_kind[b] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, R2: every slot of the decode space reads zero
        for (int a = 0; a < 64; a++) begin
            @(negedge clk); bus_addr = 8'(a << 2);
            #1 check("R1 reset read", bus_rdata, 32'h0);
        end
        check("R1 pad_oe", pad_oe[31:0] | pad_oe[63:32], 32'h0);
        check("R1 pad_out", pad_out[31:0] | pad_out[63:32], 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // R3 R4 R5 R6: direction, polarity, set/clear, level sweep
        for (int it = 0; it < 16; it++) begin
            for (int b = 0; b < NB; b++) begin
                rnd = nxt(rnd); wr(0, b, rnd); m_dir[b] = rnd;
                rnd = nxt(rnd); wr(1, b, rnd); m_pol[b] = rnd;
                rnd = nxt(rnd); wr(3, b, rnd); m_out[b] |= rnd & m_dir[b];
                check("R4 set", pad_out[b*PW +: PW], m_out[b] ^ m_pol[b]);
                rnd = nxt(rnd); wr(4, b, rnd); m_out[b] &= ~(rnd & m_dir[b]);
                check("R4 clear", pad_out[b*PW +: PW], m_out[b] ^ m_pol[b]);
                rnd = nxt(rnd); pad_in[b*PW +: PW] = rnd;
            end
            settle();
            check_all("R3 R5 R6 sweep");
        end

        // R2: writes to unmapped groups, absent banks and the level group are ignored
        for (int g = 0; g < 16; g++)
            for (int s = 0; s < 4; s++)
                if (g == 2 || g == 7 || g == 8 || g > 10 || s >= NB)
                    wr(g, s, 32'hffff_ffff);
        check_all("R2 ignored writes");
        for (int b = 0; b < NB; b++) begin
            rd(3, b, v); check("R2 set reads zero", v, 32'h0);
            rd(4, b, v); check("R2 clear reads zero", v, 32'h0);
        end

        // Prepare edge tests: inputs, no inversion, pads low
        pad_in = '0;
        for (int b = 0; b < NB; b++) begin
            wr(0, b, 0); m_dir[b] = 0;
            wr(1, b, 0); m_pol[b] = 0;
        end
        settle();
        check_all("R7 no enables no pending");

        // R7 R8 R9: each pin, each enable combination
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < PW; i++) begin
                for (int m = 0; m < 4; m++) begin
                    logic [31:0] bit1;
                    bit1 = 32'h1 << i;
                    wr(5, b, m[0] ? bit1 : 0); m_ren[b] = m[0] ? bit1 : 0;
                    wr(6, b, m[1] ? bit1 : 0); m_fen[b] = m[1] ? bit1 : 0;
                    pad_in[b*PW + i] = 1'b1;
                    settle();
                    if (m[0]) begin m_pend[b] |= bit1; m_kind[b] |= bit1; end
                    rd(9, b, v);  check("R7 rise pending", v, m_pend[b]);
                    rd(10, b, v); check("R9 rise kind", v, m_kind[b]);
                    check("R8 irq", 32'(irq), 32'(exp_irq()));
                    wr(9, b, 0);
                    rd(9, b, v);  check("R8 write zero keeps", v, m_pend[b]);
                    wr(9, b, bit1); m_pend[b] &= ~bit1;
                    check("R8 irq after clear", 32'(irq), 32'(exp_irq()));
                    pad_in[b*PW + i] = 1'b0;
                    settle();
                    if (m[1]) begin m_pend[b] |= bit1; m_kind[b] &= ~bit1; end
                    rd(9, b, v);  check("R7 fall pending", v, m_pend[b]);
                    rd(10, b, v); check("R9 fall kind", v, m_kind[b]);
                    wr(9, b, bit1); m_pend[b] &= ~bit1;
                    wr(10, b, 32'hffff_ffff); m_kind[b] = 0;
                    rd(10, b, v); check("R9 kind clear", v, 32'h0);
                end
            end
            wr(5, b, 0); m_ren[b] = 0;
            wr(6, b, 0); m_fen[b] = 0;
        end
        check_all("R7 after sweep");

        // R5 R7: inversion turns a falling pad into a rising logical edge
        wr(1, 0, 32'h0000_0100); m_pol[0] = 32'h0000_0100;
        pad_in[8] = 1'b1;
        settle();
        wr(5, 0, 32'h0000_0100); m_ren[0] = 32'h0000_0100;
        pad_in[8] = 1'b0;
        settle();
        m_pend[0] = 32'h0000_0100; m_kind[0] = 32'h0000_0100;
        check_all("R5 inverted edge");
        wr(9, 0, 32'hffff_ffff); m_pend[0] = 0;
        wr(10, 0, 32'hffff_ffff); m_kind[0] = 0;
        wr(5, 0, 0); m_ren[0] = 0;
        wr(1, 0, 0); m_pol[0] = 0;
        settle();

        // R10: event and clear of the same bit in one cycle
        wr(5, 1, 32'h20); m_ren[1] = 32'h20;
        wr(6, 1, 32'h20); m_fen[1] = 32'h20;
        pad_in[PW + 5] = 1'b1;
        settle();
        rd(9, 1, v); check("R10 setup pending", v, 32'h20);
        @(negedge clk); pad_in[PW + 5] = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = ad(9, 1); bus_wdata = 32'h20;
        @(negedge clk); bus_wr = 1'b0;
        rd(9, 1, v);  check("R10 pending survives clear", v, 32'h20);
        rd(10, 1, v); check("R10 falling kind", v, 32'h0);
        check("R10 irq", 32'(irq), 32'h1);
        wr(9, 1, 32'h20);
        rd(9, 1, v); check("R8 plain clear", v, 32'h0);
        check("R8 irq low", 32'(irq), 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule